// File: doc/BRIEF.md
# Banked Shifted-Kernel Partial Image Accumulator

This block builds the partial image contributed by one mask rectangle. Several kernel arrays are stored on chip. For each kernel and each output pixel, the block forms a signed sum of four kernel samples, one for each rectangle corner, each taken at the pixel coordinate shifted by that corner. The sum is then scaled by the rectangle's transmittance. The kernel store and the partial-sum image are each split into P×P banks selected by the low bits of the X and Y coordinates. One processing element (PE) owns each image bank. All PEs update one pixel each per cycle, in lockstep.

Work runs in a fixed order: kernel index outermost, then corner, then pixel. While a corner is fixed, each PE sweeps a regular run of shifted addresses. Because every PE has the same shift, the PEs read the kernel banks as a rotation: no two PEs ever need the same kernel bank in the same cycle. Kernels are written through a load port while the block is idle. A start strobe latches the rectangle and begins a run, and a level done flag marks completion. The results are read back by kernel and pixel address.

Top module: `lith_accum`

## Requirements
- R1: After reset, `done` is low. A kernel write with `kl_we` high while idle stores `kl_data` as kernel `kl_k` at column `kl_x` and row `kl_y`.
- R2: After a run, the partial sum for kernel k at pixel (x,y) is t·(K(x−x1+H, y−y1+H) + K(x−x2+H, y−y2+H) − K(x−x1+H, y−y2+H) − K(x−x2+H, y−y1+H)), with H = KER/2, truncated to ACC_W bits. Here K is the kernel value at (column, row), t is the signed transmittance, and corners are signed.
- R3: A kernel sample whose shifted column or row lies outside 0..KER−1 contributes zero.
- R4: Each accepted start discards the sums of earlier runs. Nothing carries over from a previous rectangle.
- R5: `done` goes low at the edge that accepts a start and rises exactly NK·4·(IMG/P)² + 3 cycles later, one cycle after the last partial-sum write. It then stays high until the next accepted start. It is never high while writes are in progress.
- R6: A start pulse while a run is in progress is ignored. The run keeps its timing and its results.
- R7: Kernel writes while a run is in progress are ignored. The stored kernel is unchanged.
- R8: The rectangle corners and the transmittance are captured at the accepting edge. Changes on those inputs during a run have no effect.
- R9: All P×P PEs write in exactly the same cycles, and only while a run is in progress. The readback port returns the sum for kernel `rd_k` at pixel (`rd_x`,`rd_y`) combinationally, from bank (x mod P, y mod P).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| x1 | input | CW | First corner column, signed |
| y1 | input | CW | First corner row, signed |
| x2 | input | CW | Second corner column, signed |
| y2 | input | CW | Second corner row, signed |
| tw | input | TW | Transmittance weight, signed |
| kl_we | input | 1 | Kernel write strobe |
| kl_k | input | log2(NK) | Kernel index to write |
| kl_x | input | log2(KER) | Kernel column to write |
| kl_y | input | log2(KER) | Kernel row to write |
| kl_data | input | KW | Kernel value, signed |
| rd_k | input | log2(NK) | Kernel index to read back |
| rd_x | input | log2(IMG) | Pixel column to read back |
| rd_y | input | log2(IMG) | Pixel row to read back |
| rd_data | output | ACC_W | Partial sum at the read address, signed |
| done | output | 1 | Run complete, held until the next start |

## Verification
A wrong bank rotation or a wrong shift sends the wrong kernel sample to a PE. This shows up as wrong sums in whole interleaved pixel columns or rows when the results are read back after `done`. A broken corner sign or a missed zero outside the kernel corrupts the sums near the rectangle edges. A stale accumulator shows up only in the run that follows another run. A fault in the sequencing shows at once in the start-to-done cycle count. The same count also exposes a restart caused by a start that should have been ignored. A kernel write that leaks into a run becomes visible in the next run with the same rectangle.

// File: rtl/lith_pkg.sv
`timescale 1ns/1ps
package lith_pkg;

  // Corners are visited 0..3 as (x1,y1) (x2,y2) (x1,y2) (x2,y1); the last two subtract.
  function automatic logic corner_neg(input logic [1:0] c);
    return c[1];
  endfunction

  function automatic logic corner_x2(input logic [1:0] c);
    return (c == 2'd1) || (c == 2'd3);
  endfunction

  function automatic logic corner_y2(input logic [1:0] c);
    return (c == 2'd1) || (c == 2'd2);
  endfunction

  // Kernel coordinate sampled for a pixel under a given corner shift.
  function automatic int kernel_coord(input int pix, input int corner, input int half);
    return pix - corner + half;
  endfunction

  function automatic logic in_span(input int v, input int n);
    return (v >= 0) && (v < n);
  endfunction

  // Signed product of a kernel sample and the weight, negated for subtracting corners.
  function automatic longint weighted(input longint kv, input longint t, input logic neg);
    longint p;
    p = kv * t;
    return neg ? -p : p;
  endfunction

endpackage

// File: rtl/lith_seq.sv
`timescale 1ns/1ps
module lith_seq #(
  parameter int NK = 2,
  parameter int IL = 4,
  parameter int KB = 1,
  parameter int LB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          last_wr,
  output logic          busy,
  output logic          done,
  output logic          iss_v,
  output logic          iss_last,
  output logic [KB-1:0] iss_k,
  output logic [1:0]    iss_c,
  output logic [LB-1:0] iss_ly,
  output logic [LB-1:0] iss_lx
);
  localparam int CNTW  = KB + 2 + 2 * LB;
  localparam int TOTAL = NK * 4 * IL * IL;

  logic [CNTW-1:0] cnt;
  logic            fin_q;

  // Flat counter: kernel in the top field, corner next, pixel row and column lowest.
  assign {iss_k, iss_c, iss_ly, iss_lx} = cnt;
  assign iss_last = iss_v && (cnt == CNTW'(TOTAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      iss_v <= 1'b0;
      cnt   <= '0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= last_wr;
      if (start && !busy) begin
        busy  <= 1'b1;
        done  <= 1'b0;
        iss_v <= 1'b1;
        cnt   <= '0;
      end else if (iss_v) begin
        if (iss_last) iss_v <= 1'b0;
        else          cnt   <= cnt + 1'b1;
      end
      if (fin_q) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lith_kbank.sv
`timescale 1ns/1ps
module lith_kbank #(
  parameter int DEPTH = 128,
  parameter int KW    = 16,
  parameter int ABW   = 7
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [ABW-1:0]       waddr,
  input  logic signed [KW-1:0] wdata,
  input  logic [ABW-1:0]       raddr,
  output logic signed [KW-1:0] rdata
);
  logic signed [KW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/lith_pe.sv
`timescale 1ns/1ps
module lith_pe
  import lith_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int KW    = 16,
  parameter int TW    = 8,
  parameter int SW    = 32,
  parameter int ABW   = 5
) (
  input  logic                 clk,
  input  logic [1:0]           s1_c,
  input  logic                 s1_inr,
  input  logic signed [KW-1:0] kdata,
  input  logic signed [TW-1:0] tw,
  input  logic                 s2_v,
  input  logic                 s2_first,
  input  logic [ABW-1:0]       waddr,
  input  logic [ABW-1:0]       rd_addr,
  output logic signed [SW-1:0] rd_data,
  output logic                 wr_evt
);
  logic signed [SW-1:0] term;
  logic signed [SW-1:0] mem [DEPTH];

  // Stage 2: scaled, signed contribution; outside the kernel it is zero.
  always_ff @(posedge clk) begin
    term <= s1_inr ? SW'(weighted(longint'(kdata), longint'(tw), corner_neg(s1_c))) : '0;
  end

  // Stage 3: the first corner of each kernel overwrites, later corners accumulate.
  always_ff @(posedge clk) begin
    if (s2_v) mem[waddr] <= (s2_first ? '0 : mem[waddr]) + term;
  end

  assign wr_evt  = s2_v;
  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/lith_accum.sv
`timescale 1ns/1ps
module lith_accum
  import lith_pkg::*;
#(
  parameter int P     = 2,
  parameter int IMG   = 8,
  parameter int KER   = 16,
  parameter int NK    = 2,
  parameter int KW    = 16,
  parameter int TW    = 8,
  parameter int ACC_W = 32,
  parameter int CW    = 6,
  localparam int KB   = (NK > 1) ? $clog2(NK) : 1,
  localparam int KXW  = $clog2(KER),
  localparam int IXW  = $clog2(IMG)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic signed [CW-1:0]    x1,
  input  logic signed [CW-1:0]    y1,
  input  logic signed [CW-1:0]    x2,
  input  logic signed [CW-1:0]    y2,
  input  logic signed [TW-1:0]    tw,
  input  logic                    kl_we,
  input  logic [KB-1:0]           kl_k,
  input  logic [KXW-1:0]          kl_x,
  input  logic [KXW-1:0]          kl_y,
  input  logic signed [KW-1:0]    kl_data,
  input  logic [KB-1:0]           rd_k,
  input  logic [IXW-1:0]          rd_x,
  input  logic [IXW-1:0]          rd_y,
  output logic signed [ACC_W-1:0] rd_data,
  output logic                    done
);
  localparam int LP     = $clog2(P);
  localparam int NPE    = P * P;
  localparam int IL     = IMG / P;
  localparam int KL     = KER / P;
  localparam int LB     = $clog2(IL);
  localparam int KLB    = $clog2(KL);
  localparam int KAW    = KB + 2 * KLB;
  localparam int KDEPTH = NK * KL * KL;
  localparam int IAW    = KB + 2 * LB;
  localparam int IDEPTH = NK * IL * IL;
  localparam int HALF   = KER / 2;

  // ---------------- sequencer ----------------
  logic          busy, iss_v, iss_last, last_wr;
  logic [KB-1:0] iss_k;
  logic [1:0]    iss_c;
  logic [LB-1:0] iss_lx, iss_ly;

  lith_seq #(.NK(NK), .IL(IL), .KB(KB), .LB(LB)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .last_wr(last_wr),
    .busy(busy), .done(done), .iss_v(iss_v), .iss_last(iss_last),
    .iss_k(iss_k), .iss_c(iss_c), .iss_ly(iss_ly), .iss_lx(iss_lx)
  );

  // Rectangle and weight captured when a start is accepted.
  logic signed [CW-1:0] x1_q, y1_q, x2_q, y2_q;
  logic signed [TW-1:0] tw_q;

  always_ff @(posedge clk) begin
    if (start && !busy) begin
      x1_q <= x1;
      y1_q <= y1;
      x2_q <= x2;
      y2_q <= y2;
      tw_q <= tw;
    end
  end

  // ---------------- issue stage: per-PE shifted kernel coordinates ----------------
  int             cx_i, cy_i;
  int             pe_kx [NPE];
  int             pe_ky [NPE];
  logic [NPE-1:0] pe_inr;
  logic [KAW-1:0] pe_kaddr [NPE];
  logic [LP-1:0]  sx, sy;

  always_comb begin
    cx_i = corner_x2(iss_c) ? int'(x2_q) : int'(x1_q);
    cy_i = corner_y2(iss_c) ? int'(y2_q) : int'(y1_q);
    for (int i = 0; i < NPE; i++) begin
      pe_kx[i]    = kernel_coord(int'(iss_lx) * P + (i % P), cx_i, HALF);
      pe_ky[i]    = kernel_coord(int'(iss_ly) * P + (i / P), cy_i, HALF);
      pe_inr[i]   = in_span(pe_kx[i], KER) && in_span(pe_ky[i], KER);
      pe_kaddr[i] = {iss_k, pe_ky[i][LP +: KLB], pe_kx[i][LP +: KLB]};
    end
  end

  // Bank rotation for this corner: PE (bx,by) reads kernel bank (bx+sx, by+sy).
  assign sx = pe_kx[0][LP-1:0];
  assign sy = pe_ky[0][LP-1:0];

  // ---------------- stage 1 / stage 2 control ----------------
  logic           s1_v, s1_last, s2_v, s2_last;
  logic [KB-1:0]  s1_k;
  logic [1:0]     s1_c, s2_c;
  logic [LB-1:0]  s1_lx, s1_ly;
  logic [LP-1:0]  s1_sx, s1_sy;
  logic [NPE-1:0] s1_inr;
  logic [IAW-1:0] s2_waddr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_last <= 1'b0;
      s2_v    <= 1'b0;
      s2_last <= 1'b0;
    end else begin
      s1_v    <= iss_v;
      s1_last <= iss_last;
      s2_v    <= s1_v;
      s2_last <= s1_last;
    end
  end

  always_ff @(posedge clk) begin
    s1_k     <= iss_k;
    s1_c     <= iss_c;
    s1_lx    <= iss_lx;
    s1_ly    <= iss_ly;
    s1_sx    <= sx;
    s1_sy    <= sy;
    s1_inr   <= pe_inr;
    s2_c     <= s1_c;
    s2_waddr <= {s1_k, s1_ly, s1_lx};
  end

  assign last_wr = s2_v && s2_last;

  // ---------------- kernel banks ----------------
  logic [KAW-1:0]       kl_addr;
  logic signed [KW-1:0] kb_q [NPE];

  assign kl_addr = {kl_k, kl_y[KXW-1:LP], kl_x[KXW-1:LP]};

  for (genvar q = 0; q < NPE; q++) begin : g_kbank
    logic [LP-1:0] ptx, pty;
    logic          we_q;
    // Which PE needs this bank under the current rotation.
    assign ptx  = LP'(q % P) - sx;
    assign pty  = LP'(q / P) - sy;
    assign we_q = kl_we && !busy && (kl_x[LP-1:0] == LP'(q % P)) && (kl_y[LP-1:0] == LP'(q / P));

    lith_kbank #(.DEPTH(KDEPTH), .KW(KW), .ABW(KAW)) u_kb (
      .clk(clk), .we(we_q), .waddr(kl_addr), .wdata(kl_data),
      .raddr(pe_kaddr[{pty, ptx}]), .rdata(kb_q[q])
    );
  end

  // ---------------- processing elements ----------------
  logic [IAW-1:0]          rd_addr;
  logic [2*LP-1:0]         rd_pe;
  logic signed [ACC_W-1:0] pe_rd [NPE];
  logic [NPE-1:0]          pe_wr;

  assign rd_addr = {rd_k, rd_y[IXW-1:LP], rd_x[IXW-1:LP]};
  assign rd_pe   = {rd_y[LP-1:0], rd_x[LP-1:0]};

  for (genvar i = 0; i < NPE; i++) begin : g_pe
    logic [LP-1:0] rbx, rby;
    assign rbx = LP'(i % P) + s1_sx;
    assign rby = LP'(i / P) + s1_sy;

    lith_pe #(.DEPTH(IDEPTH), .KW(KW), .TW(TW), .SW(ACC_W), .ABW(IAW)) u_pe (
      .clk(clk), .s1_c(s1_c), .s1_inr(s1_inr[i]), .kdata(kb_q[{rby, rbx}]),
      .tw(tw_q), .s2_v(s2_v), .s2_first(s2_c == 2'd0), .waddr(s2_waddr),
      .rd_addr(rd_addr), .rd_data(pe_rd[i]), .wr_evt(pe_wr[i])
    );
  end

  assign rd_data = pe_rd[rd_pe];
endmodule

// File: rtl/lith_accum_chk.sv
`timescale 1ns/1ps
module lith_accum_chk #(
  parameter int NPE = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           done,
  input logic           last_wr,
  input logic [NPE-1:0] pe_wr
);
  // R5
  last_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_wr |=> ##1 done);

  // R5
  done_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(last_wr, 2));

  // R5
  no_done_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pe_wr) |-> !done);

  // R9
  pe_lockstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_wr == '0) || (&pe_wr));

  // R9
  write_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pe_wr) |-> busy);

  // R6
  busy_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));
endmodule

bind lith_accum lith_accum_chk #(.NPE(NPE)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .last_wr(last_wr), .pe_wr(pe_wr)
);

// File: tb/tb_lith_accum.sv
`timescale 1ns/1ps
module tb_lith_accum;
  localparam int P = 2, IMG = 8, KER = 16, NK = 2, KW = 16, TW = 8, AW = 32, CW = 6;
  localparam int IL = IMG / P;
  localparam int RUNLEN = NK * 4 * IL * IL + 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic signed [CW-1:0] x1 = '0, y1 = '0, x2 = '0, y2 = '0;
  logic signed [TW-1:0] tw = '0;
  logic kl_we = 1'b0;
  logic [0:0] kl_k = '0, rd_k = '0;
  logic [3:0] kl_x = '0, kl_y = '0;
  logic signed [KW-1:0] kl_data = '0;
  logic [2:0] rd_x = '0, rd_y = '0;
  logic signed [AW-1:0] rd_data;
  logic done;

  lith_accum dut (
    .clk(clk), .rst_n(rst_n), .start(start), .x1(x1), .y1(y1), .x2(x2), .y2(y2),
    .tw(tw), .kl_we(kl_we), .kl_k(kl_k), .kl_x(kl_x), .kl_y(kl_y), .kl_data(kl_data),
    .rd_k(rd_k), .rd_x(rd_x), .rd_y(rd_y), .rd_data(rd_data), .done(done)
  );

  always #5 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;
  int kmem [NK][KER][KER];

  typedef struct {int k; int x; int y; longint val; string req;} item_t;
  item_t sb [$];
  event drain_go, drain_end;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  function automatic int kval(int k, int x, int y);
    return ((k * 53 + x * 29 + y * 17 + x * y * 3) % 251) - 125;
  endfunction

  // Kernel tap with zero outside the stored array (R3).
  function automatic longint tap(int k, int x, int y);
    if (x < 0 || x >= KER || y < 0 || y >= KER) return 0;
    return longint'(kmem[k][x][y]);
  endfunction

  // Driver side of the scoreboard: box-difference reference for every kernel and pixel (R2).
  task automatic push_expect(int a, int b, int c, int d, int t, string req);
    for (int k = 0; k < NK; k++)
      for (int py = 0; py < IMG; py++)
        for (int px = 0; px < IMG; px++) begin
          item_t it;
          longint box;
          box = tap(k, px - a + KER/2, py - b + KER/2) + tap(k, px - c + KER/2, py - d + KER/2)
              - tap(k, px - a + KER/2, py - d + KER/2) - tap(k, px - c + KER/2, py - b + KER/2);
          it.k = k; it.x = px; it.y = py; it.req = req;
          it.val = longint'(AW'(longint'(t) * box));
          sb.push_back(it);
        end
  endtask

  // Monitor: pops expected items and compares them with the readback port (R9).
  initial begin
    forever begin
      @(drain_go);
      while (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        @(negedge clk);
        rd_k = 1'(it.k); rd_x = 3'(it.x); rd_y = 3'(it.y);
        #1;
        check(longint'(rd_data) == it.val, it.req, "partial sum readback", longint'(rd_data), it.val);
      end
      ->drain_end;
    end
  end

  task automatic run(int a, int b, int c, int d, int t, bit disturb, string req);
    int n;
    @(negedge clk);
    x1 = CW'(a); y1 = CW'(b); x2 = CW'(c); y2 = CW'(d); tw = TW'(t); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R5: accepting edge clears done
    check(done == 1'b0, "R5", "done after accepted start", longint'(done), 0);
    n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
      if (disturb && n == 10) begin
        // R6 R7 R8: start, kernel write and new rectangle inputs during a run
        start = 1'b1; x1 = 6'sd0; y1 = 6'sd0; x2 = 6'sd7; y2 = 6'sd7; tw = 8'sd100;
        kl_we = 1'b1; kl_k = 1'b0; kl_x = 4'd8; kl_y = 4'd8; kl_data = 16'sd12345;
      end
      if (disturb && n == 11) begin
        start = 1'b0; kl_we = 1'b0;
      end
    end
    check(n == RUNLEN, disturb ? "R6" : "R5", "cycles from start to done", n, RUNLEN);
    push_expect(a, b, c, d, t, req);
    ->drain_go;
    @(drain_end);
    repeat (3) @(negedge clk);
    // R5: done holds until the next start
    check(done == 1'b1, "R5", "done held while idle", longint'(done), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R5 watchdog: actual no completion expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(done == 1'b0, "R1", "done during reset", longint'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R1", "done after reset", longint'(done), 0);

    // R1: load all kernels through the load port
    for (int k = 0; k < NK; k++)
      for (int y = 0; y < KER; y++)
        for (int x = 0; x < KER; x++) begin
          kmem[k][x][y] = kval(k, x, y);
          @(negedge clk);
          kl_we = 1'b1; kl_k = 1'(k); kl_x = 4'(x); kl_y = 4'(y); kl_data = KW'(kmem[k][x][y]);
        end
    @(negedge clk);
    kl_we = 1'b0;

    run(2, 1, 5, 6, 3, 1'b0, "R2");          // rectangle inside the kernel
    run(-12, 3, 14, -9, -7, 1'b0, "R3");     // corners pushing samples off the kernel; R4 fresh sums
    run(4, 2, 4, 6, 9, 1'b0, "R2");          // zero-width rectangle cancels everywhere
    run(2, 1, 5, 6, 3, 1'b1, "R8");          // disturbances during the run are ignored
    run(2, 1, 5, 6, 3, 1'b0, "R7");          // kernel unchanged by the write during a run
    run(-3, -2, 1, 9, -128, 1'b0, "R4");     // extreme weight, results replace earlier run
    finish_up();
  end
endmodule